// File: doc/BRIEF.md
# Machine Status Register Write Path

This block holds the machine-level status word of a processor hart and serves it through two views. The full machine view is read and written over its own port. A narrower supervisor view shows only the supervisor-visible subset, and a write to it is merged into the full word and then handled by the same legalizing logic as a machine write. Every write is filtered against a fixed set of legal fields. A previous-privilege value that names a mode the hart does not support is discarded. The dirty summary bit is always derived from the state, never taken from the write data.

When a write changes any field that affects address translation, the block raises a one-cycle flush request so that cached translations can be thrown away. Whether supervisor and user modes exist is given by two configuration inputs, and these decide which previous-privilege values are legal. Updates made by trap entry and trap return are handled elsewhere.

Top module: `mstat_core`

## Requirements
- R1: After reset the machine view reads 0x0000_1800 (previous-privilege field = 3, machine mode, all other bits 0), the supervisor view reads 0 and the flush output is low.
- R2: A machine write updates only the writable bits 1, 3, 5, 7, 8, 11 to 14 and 17 to 22, and the new value is visible on the read port in the cycle after the write. Every other bit keeps its value, including bits 0, 4, 9, 10, 15, 16 and 23 to 30.
- R3: When the previous-privilege field (bits 12:11) of a write is 2, that field keeps its old value and the other writable fields are still written.
- R4: A previous-privilege value of 1 is discarded when supervisor support is off, and a value of 0 is discarded when user support is off. Both values are accepted when the matching support input is high.
- R5: The summary bit (bit 31) reads 1 exactly when bits 14:13 or bits 16:15 equal 3. It is recomputed after every write, and the value written to bit 31 has no effect.
- R6: The flush output is high for one cycle, in the cycle after a write, when the written value (after the supervisor merge, for a supervisor write) differs from the old word in bit 17, 18, 19 or bits 12:11. This holds even when the previous-privilege part of that write is discarded. The flush output is low otherwise.
- R7: The supervisor view reads the full word masked to bits 0, 1, 4, 5, 8, 13 to 16, 18, 19 and 31, with all other bits 0.
- R8: A supervisor write replaces only the bits of the supervisor mask in the full word and then follows R2 to R6. Bits outside the supervisor mask never change on a supervisor write.
- R9: When both write enables are high in the same cycle, only the machine write takes effect.
- R10: With no write enable high, the word does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sup_present | input | 1 | Supervisor mode is implemented |
| usr_present | input | 1 | User mode is implemented |
| m_wr_en | input | 1 | Machine-view write strobe |
| m_wr_data | input | XLEN | Machine-view write value |
| s_wr_en | input | 1 | Supervisor-view write strobe |
| s_wr_data | input | XLEN | Supervisor-view write value |
| m_rd_data | output | XLEN | Machine-view read value |
| s_rd_data | output | XLEN | Supervisor-view read value |
| xlat_flush | output | 1 | One-cycle translation flush request |

## Verification
The embedded properties assume that the write strobes, write data and support inputs carry known values in every cycle after reset, and that the support inputs change only between clock edges. They do not assume that the support inputs stay fixed. The stimulus drives every input at the falling edge with fully defined values, often toggles the support configuration, and biases the privilege and floating-point state fields so that the rejected, accepted and dirty cases all occur many times.

// File: rtl/mstat_pkg.sv
package mstat_pkg;

    localparam int UIE_B  = 0;
    localparam int SIE_B  = 1;
    localparam int MIE_B  = 3;
    localparam int UPIE_B = 4;
    localparam int SPIE_B = 5;
    localparam int MPIE_B = 7;
    localparam int SPP_B  = 8;
    localparam int MPP_LO = 11;
    localparam int FS_LO  = 13;
    localparam int XS_LO  = 15;
    localparam int MPRV_B = 17;
    localparam int SUM_B  = 18;
    localparam int MXR_B  = 19;
    localparam int TVM_B  = 20;
    localparam int TW_B   = 21;
    localparam int TSR_B  = 22;

    typedef enum logic [1:0] {
        PRIV_USR  = 2'd0,
        PRIV_SUP  = 2'd1,
        PRIV_RSVD = 2'd2,
        PRIV_MACH = 2'd3
    } priv_e;

    // Fields a machine write may change (summary bit excluded).
    function automatic logic [63:0] legal_mask();
        logic [63:0] m;
        m = '0;
        m[SIE_B]  = 1'b1;
        m[MIE_B]  = 1'b1;
        m[SPIE_B] = 1'b1;
        m[MPIE_B] = 1'b1;
        m[SPP_B]  = 1'b1;
        m[MPP_LO +: 2] = 2'b11;
        m[FS_LO +: 2]  = 2'b11;
        m[MPRV_B] = 1'b1;
        m[SUM_B]  = 1'b1;
        m[MXR_B]  = 1'b1;
        m[TVM_B]  = 1'b1;
        m[TW_B]   = 1'b1;
        m[TSR_B]  = 1'b1;
        return m;
    endfunction

    // Low part of the supervisor view (summary bit added per width).
    function automatic logic [63:0] sview_mask();
        logic [63:0] m;
        m = '0;
        m[UIE_B]  = 1'b1;
        m[SIE_B]  = 1'b1;
        m[UPIE_B] = 1'b1;
        m[SPIE_B] = 1'b1;
        m[SPP_B]  = 1'b1;
        m[FS_LO +: 2] = 2'b11;
        m[XS_LO +: 2] = 2'b11;
        m[SUM_B]  = 1'b1;
        m[MXR_B]  = 1'b1;
        return m;
    endfunction

    // Fields whose change invalidates cached translations.
    function automatic logic [63:0] xlat_mask();
        logic [63:0] m;
        m = '0;
        m[MPP_LO +: 2] = 2'b11;
        m[MPRV_B] = 1'b1;
        m[SUM_B]  = 1'b1;
        m[MXR_B]  = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/mstat_view_merge.sv
module mstat_view_merge
    import mstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_word,
    input  logic            m_en,
    input  logic [XLEN-1:0] m_data,
    input  logic            s_en,
    input  logic [XLEN-1:0] s_data,
    output logic            cand_valid,
    output logic [XLEN-1:0] cand_word
);

    localparam int SD_B = XLEN - 1;
    localparam logic [63:0] SV_LOW = sview_mask();

    function automatic logic [XLEN-1:0] build_smask();
        logic [XLEN-1:0] m;
        m = SV_LOW[XLEN-1:0];
        m[SD_B] = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] SMASK = build_smask();

    logic [XLEN-1:0] s_merged;

    always_comb begin
        s_merged   = (cur_word & ~SMASK) | (s_data & SMASK);
        cand_valid = m_en | s_en;
        // machine port takes precedence over the supervisor alias
        if (m_en) begin
            cand_word = m_data;
        end else if (s_en) begin
            cand_word = s_merged;
        end else begin
            cand_word = cur_word;
        end
    end

endmodule

// File: rtl/mstat_field_filter.sv
module mstat_field_filter
    import mstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_word,
    input  logic [XLEN-1:0] cand_word,
    input  logic            sup_ok,
    input  logic            usr_ok,
    output logic [XLEN-1:0] next_word,
    output logic            flush_req
);

    localparam int SD_B = XLEN - 1;
    localparam logic [63:0] LEGAL64 = legal_mask();
    localparam logic [63:0] XLAT64  = xlat_mask();
    localparam logic [XLEN-1:0] LEGAL = LEGAL64[XLEN-1:0];
    localparam logic [XLEN-1:0] XLAT  = XLAT64[XLEN-1:0];

    function automatic logic [XLEN-1:0] build_mpp_mask();
        logic [XLEN-1:0] m;
        m = '0;
        m[MPP_LO +: 2] = 2'b11;
        return m;
    endfunction

    localparam logic [XLEN-1:0] MPP_M = build_mpp_mask();

    priv_e           mpp_req;
    logic            mpp_ok;
    logic [XLEN-1:0] eff_mask;
    logic [XLEN-1:0] merged;

    always_comb begin
        mpp_req = priv_e'(cand_word[MPP_LO +: 2]);
        unique case (mpp_req)
            PRIV_RSVD: mpp_ok = 1'b0;
            PRIV_SUP:  mpp_ok = sup_ok;
            PRIV_USR:  mpp_ok = usr_ok;
            default:   mpp_ok = 1'b1;
        endcase
        eff_mask = mpp_ok ? LEGAL : (LEGAL & ~MPP_M);
        merged   = (cur_word & ~eff_mask) | (cand_word & eff_mask);
        merged[SD_B] = (merged[FS_LO +: 2] == 2'b11) || (merged[XS_LO +: 2] == 2'b11);
        next_word = merged;
        // compared on the requested value, before field rejection
        flush_req = |((cand_word ^ cur_word) & XLAT);
    end

endmodule

// File: rtl/mstat_core.sv
module mstat_core
    import mstat_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sup_present,
    input  logic            usr_present,
    input  logic            m_wr_en,
    input  logic [XLEN-1:0] m_wr_data,
    input  logic            s_wr_en,
    input  logic [XLEN-1:0] s_wr_data,
    output logic [XLEN-1:0] m_rd_data,
    output logic [XLEN-1:0] s_rd_data,
    output logic            xlat_flush
);

    localparam int SD_B = XLEN - 1;
    localparam logic [63:0] LEGAL64 = legal_mask();
    localparam logic [63:0] SV64    = sview_mask();

    function automatic logic [XLEN-1:0] build_reset();
        logic [XLEN-1:0] v;
        v = '0;
        v[MPP_LO +: 2] = PRIV_MACH;
        return v;
    endfunction

    function automatic logic [XLEN-1:0] build_smask();
        logic [XLEN-1:0] m;
        m = SV64[XLEN-1:0];
        m[SD_B] = 1'b1;
        return m;
    endfunction

    localparam logic [XLEN-1:0] RESET_WORD = build_reset();
    localparam logic [XLEN-1:0] SMASK      = build_smask();
    localparam logic [XLEN-1:0] FIXED      =
        ~(LEGAL64[XLEN-1:0] | (XLEN'(1) << SD_B));

    typedef struct packed {
        logic [XLEN-1:0] word;
        logic            flush;
    } state_t;

    state_t st_d, st_q;

    logic            cand_valid;
    logic [XLEN-1:0] cand_word;
    logic [XLEN-1:0] filt_word;
    logic            filt_flush;

    mstat_view_merge #(.XLEN(XLEN)) u_merge (
        .cur_word   (st_q.word),
        .m_en       (m_wr_en),
        .m_data     (m_wr_data),
        .s_en       (s_wr_en),
        .s_data     (s_wr_data),
        .cand_valid (cand_valid),
        .cand_word  (cand_word)
    );

    mstat_field_filter #(.XLEN(XLEN)) u_filter (
        .cur_word  (st_q.word),
        .cand_word (cand_word),
        .sup_ok    (sup_present),
        .usr_ok    (usr_present),
        .next_word (filt_word),
        .flush_req (filt_flush)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flush = 1'b0;
        if (cand_valid) begin
            st_d.word  = filt_word;
            st_d.flush = filt_flush;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.word  <= RESET_WORD;
            st_q.flush <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_rd_data  = st_q.word;
    assign s_rd_data  = st_q.word & SMASK;
    assign xlat_flush = st_q.flush;

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!m_wr_en && !s_wr_en) |=> $stable(m_rd_data)); // R10

    AST_FIXED_BITS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(m_rd_data & FIXED)); // R2

    AST_MPP_NOT_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
        m_rd_data[MPP_LO +: 2] != 2'b10); // R3

    AST_RSVD_MPP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_en && m_wr_data[MPP_LO +: 2] == 2'b10)
        |=> $stable(m_rd_data[MPP_LO +: 2])); // R3

    AST_SUMMARY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        m_rd_data[SD_B] == ((m_rd_data[FS_LO +: 2] == 2'b11) ||
                            (m_rd_data[XS_LO +: 2] == 2'b11))); // R5

    AST_FLUSH_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_flush |-> $past(m_wr_en || s_wr_en)); // R6

    AST_SVIEW_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd_data & ~SMASK) == '0); // R7

    AST_SWRITE_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (s_wr_en && !m_wr_en) |=> $stable(m_rd_data & ~SMASK)); // R8

endmodule

// File: tb/mstat_core_test.sv
module mstat_core_test;

    localparam logic [31:0] WMASK = 32'h007E_79AA;
    localparam logic [31:0] SMASK = 32'h800D_E133;
    localparam logic [31:0] XMASK = 32'h000E_1800;
    localparam logic [31:0] MPPM  = 32'h0000_1800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sup_present = 1'b1;
    logic        usr_present = 1'b1;
    logic        m_wr_en = 1'b0;
    logic [31:0] m_wr_data = '0;
    logic        s_wr_en = 1'b0;
    logic [31:0] s_wr_data = '0;
    logic [31:0] m_rd_data;
    logic [31:0] s_rd_data;
    logic        xlat_flush;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] model = 32'h0000_1800;

    always #2 clk = ~clk;

    mstat_core #(.XLEN(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .sup_present(sup_present), .usr_present(usr_present),
        .m_wr_en(m_wr_en), .m_wr_data(m_wr_data),
        .s_wr_en(s_wr_en), .s_wr_data(s_wr_data),
        .m_rd_data(m_rd_data), .s_rd_data(s_rd_data),
        .xlat_flush(xlat_flush)
    );

    function automatic logic [31:0] ref_next(input logic [31:0] cur,
            input logic [31:0] req, input logic sup, input logic usr,
            output logic fl);
        logic [31:0] mask;
        logic [1:0]  mpp;
        logic [31:0] nw;
        mpp  = req[12:11];
        mask = WMASK;
        if (mpp == 2'd2 || (mpp == 2'd1 && !sup) || (mpp == 2'd0 && !usr))
            mask = mask & ~MPPM;
        nw = (cur & ~mask) | (req & mask);
        nw[31] = (nw[14:13] == 2'b11) || (nw[16:15] == 2'b11);
        fl = |((req ^ cur) & XMASK);
        return nw;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic step(input logic men, input logic [31:0] md,
                        input logic sen, input logic [31:0] sd,
                        input string tag);
        logic        efl;
        logic [31:0] req;
        m_wr_en = men; m_wr_data = md;
        s_wr_en = sen; s_wr_data = sd;
        efl = 1'b0;
        if (men) begin
            req = md;
            model = ref_next(model, req, sup_present, usr_present, efl);
        end else if (sen) begin
            req = (model & ~SMASK) | (sd & SMASK);
            model = ref_next(model, req, sup_present, usr_present, efl);
        end
        @(negedge clk);
        m_wr_en = 1'b0; s_wr_en = 1'b0;
        check(m_rd_data === model, tag, m_rd_data, model);
        check(s_rd_data === (model & SMASK), "R7 sview", s_rd_data, model & SMASK);
        check(xlat_flush === efl, "R6 flush", {31'd0, xlat_flush}, {31'd0, efl});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(m_rd_data === 32'h0000_1800, "R1 mview", m_rd_data, 32'h0000_1800);
        check(s_rd_data === 32'h0, "R1 sview", s_rd_data, 32'h0);
        check(xlat_flush === 1'b0, "R1 flush", {31'd0, xlat_flush}, 32'h0);

        // R2: all ones only reaches writable bits
        step(1'b1, 32'hFFFF_FFFF, 1'b0, '0, "R2 all-ones");
        step(1'b1, 32'h0000_0000, 1'b0, '0, "R2 all-zeros");
        // R6: no change to translation fields -> no pulse, then pulse from MXR
        step(1'b1, 32'h0000_0000, 1'b0, '0, "R6 no change");
        step(1'b1, 32'h0008_0000, 1'b0, '0, "R6 mxr change");
        step(1'b0, '0, 1'b0, '0, "R10 idle after pulse");
        // R3: reserved privilege value kept out, rest written
        step(1'b1, 32'h0000_10AA, 1'b0, '0, "R3 reserved mpp");
        // R4: supervisor and user legality
        sup_present = 1'b0;
        step(1'b1, 32'h0000_0800, 1'b0, '0, "R4 sup absent");
        sup_present = 1'b1;
        step(1'b1, 32'h0000_0800, 1'b0, '0, "R4 sup present");
        usr_present = 1'b0;
        step(1'b1, 32'h0000_0000, 1'b0, '0, "R4 usr absent");
        usr_present = 1'b1;
        step(1'b1, 32'h0000_0000, 1'b0, '0, "R4 usr present");
        // R5: summary bit derived from state
        step(1'b1, 32'h8000_2000, 1'b0, '0, "R5 sd write ignored");
        step(1'b1, 32'h0000_6000, 1'b0, '0, "R5 fs dirty");
        step(1'b1, 32'h0000_0000, 1'b0, '0, "R5 fs clean");
        // R8: supervisor alias write
        step(1'b0, '0, 1'b1, 32'hFFFF_FFFF, "R8 sview all-ones");
        step(1'b0, '0, 1'b1, 32'h0000_0000, "R8 sview zeros");
        // R9: both strobes, machine wins
        step(1'b1, 32'h0000_0088, 1'b1, 32'h000C_0022, "R9 priority");
        // R10: idle cycles
        step(1'b0, '0, 1'b0, '0, "R10 idle");

        for (int i = 0; i < 3000; i++) begin
            logic        men, sen;
            logic [31:0] md, sd;
            if ($urandom_range(0, 7) == 0) sup_present = 1'($urandom);
            if ($urandom_range(0, 7) == 0) usr_present = 1'($urandom);
            men = ($urandom_range(0, 2) == 0);
            sen = ($urandom_range(0, 2) == 0);
            md = $urandom;
            sd = $urandom;
            if ($urandom_range(0, 1) == 0) md = md & 32'h0000_7800 | (model & ~32'h0000_7800);
            if (men && sen)
                step(men, md, sen, sd, "R9 random");
            else if (men)
                step(men, md, sen, sd, "R2 random");
            else if (sen)
                step(men, md, sen, sd, "R8 random");
            else
                step(men, md, sen, sd, "R10 random");
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule